// File: doc/BRIEF.md
# Infrared remote control receiver

The block turns a demodulated, active-low remote-control pulse train into data words. The pulse train is sampled on a slow reference clock. Once enabled, it looks for a leader: a low level whose width lies in a window, then a high level whose width lies in a second window. After the leader it measures the period from one falling edge to the next. It stores one bit per period, 1 when the period reaches a threshold and 0 otherwise, in a shift buffer of up to 72 bits. A frame ends in one of two ways: no falling edge arrives within a maximum bit cycle, or the line stays low longer than a limit. On completion the buffer, its bit count and the end reason are latched to the outputs, and the receiver goes back to waiting.

Software sets the receiver up through a small write-only register port before raising the enable input. Sticky flags record leader detection, data edges and frame completion. Each flag is cleared by writing 1 to its bit. One-cycle interrupt pulses come with the flags. In leaderless mode the receiver skips the leader search: the first falling edge opens a frame directly.

Top module: `irr_top`

## Requirements
- R1: While en_i is low, no flag is set, no interrupt pulses, and no frame completes. Lowering en_i abandons a frame in progress.
- R2: A leader is accepted only if two conditions hold, both counted in clock cycles: the low width is within [min,max] of register 0, and the following high width is within [min,max] of register 1. Min sits in bits 15:0 and max in bits 31:16. A failed leader accepts no data bits.
- R3: An accepted leader always sets flag_leader_o. It pulses irq_leader_o for one cycle only when control bit 16 (register 3) is 1.
- R4: Each falling edge in a frame closes one bit. The bit is 1 when the edge-to-edge period is at least the threshold (register 2 bits 15:0) and 0 otherwise. After a frame of n bits, rx_bits_o = n and rx_buf_o[n-1:0] holds the bits, the last one at bit 0 and the earliest at bit n-1.
- R5: When control bit 17 is 1, every bit-closing falling edge sets flag_edge_o and pulses irq_edge_o once. When the bit is 0, neither happens.
- R6: If no falling edge arrives within the maximum cycle (register 2 bits 31:16) after the last one, the frame completes with end_max_o=1 and end_low_o=0.
- R7: If the line stays low for more than the low limit (register 3 bits 15:0), the frame completes with end_low_o=1 and end_max_o=0.
- R8: Every completion sets flag_done_o and gives exactly one one-cycle pulse on irq_done_o. The receiver then waits for the next leader.
- R9: Beyond 72 bits, rx_bits_o saturates at 72 and rx_buf_o keeps the latest 72 bits.
- R10: With control bit 18 set, the first falling edge opens a frame without any leader. flag_leader_o stays clear.
- R11: A new completion overwrites rx_buf_o, rx_bits_o and the end reason even when flag_done_o is still set.
- R12: Writing register 4 clears flag_leader_o, flag_edge_o and flag_done_o for each of bits 0, 1 and 2 that is 1. The other flags are left as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Reception enable |
| ir_i | input | 1 | Demodulated pulse input, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address (0..4) |
| cfg_wdata_i | input | 32 | Register write data |
| rx_buf_o | output | 72 | Latched received bits |
| rx_bits_o | output | 7 | Latched bit count |
| end_max_o | output | 1 | Last frame ended on maximum cycle |
| end_low_o | output | 1 | Last frame ended on long low |
| flag_leader_o | output | 1 | Sticky leader flag |
| flag_edge_o | output | 1 | Sticky data-edge flag |
| flag_done_o | output | 1 | Sticky completion flag |
| irq_leader_o | output | 1 | Leader interrupt pulse |
| irq_edge_o | output | 1 | Data-edge interrupt pulse |
| irq_done_o | output | 1 | Completion interrupt pulse |

## Verification
Frames that mix short and long periods test whether classification follows the threshold and whether the bits come out in the right order. A frame that ends with a long high and one that ends with a held low separate the two end reasons. A leader whose low width is too short, and a frame sent with enable low, must produce nothing. A 75-bit frame exercises saturation. Back-to-back frames with no clearing show overwrite, leaderless mode shows that the first edge opens the frame without a leader, and turning the interrupt enables on and off separates flags from pulses.

// File: rtl/irr_pkg.sv
package irr_pkg;
  typedef enum logic [2:0] {
    S_OFF   = 3'd0,
    S_WAIT  = 3'd1,
    S_LLOW  = 3'd2,
    S_LHIGH = 3'd3,
    S_DATA  = 3'd4
  } irr_state_e;

  localparam logic [2:0] ADDR_LDR_LO = 3'd0;
  localparam logic [2:0] ADDR_LDR_HI = 3'd1;
  localparam logic [2:0] ADDR_BIT    = 3'd2;
  localparam logic [2:0] ADDR_CTRL   = 3'd3;
  localparam logic [2:0] ADDR_CLR    = 3'd4;
endpackage

// File: rtl/irr_sync_edge.sv
module irr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign fall_o = prev_q & ~lvl_o;
  assign rise_o = ~prev_q & lvl_o;
endmodule

// File: rtl/irr_meter.sv
module irr_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] run_o,
  output logic [CNT_W-1:0] cyc_o
);
  localparam logic [CNT_W-1:0] SAT = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] run_q, cyc_q;

  // run: length of current level; cyc: cycles since last falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      cyc_q <= '0;
    end else if (clr_i) begin
      run_q <= '0;
      cyc_q <= '0;
    end else begin
      if (fall_i || rise_i) run_q <= ONE;
      else if (run_q != SAT) run_q <= run_q + ONE;
      if (fall_i) cyc_q <= ONE;
      else if (cyc_q != SAT) cyc_q <= cyc_q + ONE;
    end
  end

  assign run_o = run_q;
  assign cyc_o = cyc_q;
endmodule

// File: rtl/irr_shreg.sv
module irr_shreg #(
  parameter int BUF_W = 72,
  localparam int CW   = $clog2(BUF_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [BUF_W-1:0] data_o,
  output logic [CW-1:0]    cnt_o
);
  localparam logic [CW-1:0] FULL = CW'(BUF_W);

  logic [BUF_W-1:0] data_q;
  logic [CW-1:0]    cnt_q;

  for (genvar i = 0; i < BUF_W; i++) begin : g_cell
    logic d_in;
    if (i == 0) begin : g_head
      assign d_in = bit_i;
    end else begin : g_body
      assign d_in = data_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      data_q[i] <= 1'b0;
      else if (clr_i)   data_q[i] <= 1'b0;
      else if (shift_i) data_q[i] <= d_in;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i)                   cnt_q <= '0;
    else if (shift_i && cnt_q != FULL) cnt_q <= cnt_q + CW'(1);
  end

  assign data_o = data_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/irr_top.sv
module irr_top import irr_pkg::*; #(
  parameter int BUF_W = 72,
  parameter int CNT_W = 16,
  localparam int DW   = 2 * CNT_W,
  localparam int CW   = $clog2(BUF_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ir_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic [BUF_W-1:0] rx_buf_o,
  output logic [CW-1:0]    rx_bits_o,
  output logic             end_max_o,
  output logic             end_low_o,
  output logic             flag_leader_o,
  output logic             flag_edge_o,
  output logic             flag_done_o,
  output logic             irq_leader_o,
  output logic             irq_edge_o,
  output logic             irq_done_o
);
  // configuration
  logic [CNT_W-1:0] llo_min_q, llo_max_q, lhi_min_q, lhi_max_q;
  logic [CNT_W-1:0] thr_q, maxc_q, lowl_q;
  logic             lien_q, eien_q, nold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      llo_min_q <= '0; llo_max_q <= '0;
      lhi_min_q <= '0; lhi_max_q <= '0;
      thr_q     <= '0; maxc_q    <= '0;
      lowl_q    <= '0;
      lien_q    <= 1'b0; eien_q <= 1'b0; nold_q <= 1'b0;
    end else if (cfg_we_i) begin
      unique case (cfg_addr_i)
        ADDR_LDR_LO: begin
          llo_min_q <= cfg_wdata_i[CNT_W-1:0];
          llo_max_q <= cfg_wdata_i[CNT_W +: CNT_W];
        end
        ADDR_LDR_HI: begin
          lhi_min_q <= cfg_wdata_i[CNT_W-1:0];
          lhi_max_q <= cfg_wdata_i[CNT_W +: CNT_W];
        end
        ADDR_BIT: begin
          thr_q  <= cfg_wdata_i[CNT_W-1:0];
          maxc_q <= cfg_wdata_i[CNT_W +: CNT_W];
        end
        ADDR_CTRL: begin
          lowl_q <= cfg_wdata_i[CNT_W-1:0];
          lien_q <= cfg_wdata_i[CNT_W];
          eien_q <= cfg_wdata_i[CNT_W+1];
          nold_q <= cfg_wdata_i[CNT_W+2];
        end
        default: ;
      endcase
    end
  end

  logic [2:0] w1c;
  assign w1c = (cfg_we_i && cfg_addr_i == ADDR_CLR) ? cfg_wdata_i[2:0] : 3'b000;

  // input conditioning and timing
  logic lvl, fall, rise;
  irr_sync_edge #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(ir_i), .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
  );

  irr_state_e       state_q, state_d;
  logic [CNT_W-1:0] run, cyc;

  irr_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i, .rst_ni, .clr_i(state_q == S_OFF),
    .fall_i(fall), .rise_i(rise), .run_o(run), .cyc_o(cyc)
  );

  // frame sequencer
  logic ev_ldr, ev_bit, ev_end, end_is_max, bit_val;
  logic llo_ok, lhi_ok;

  assign llo_ok  = (run >= llo_min_q) && (run <= llo_max_q);
  assign lhi_ok  = (run >= lhi_min_q) && (run <= lhi_max_q);
  assign bit_val = (cyc >= thr_q);

  always_comb begin
    state_d    = state_q;
    ev_ldr     = 1'b0;
    ev_bit     = 1'b0;
    ev_end     = 1'b0;
    end_is_max = 1'b0;
    if (!en_i) begin
      state_d = S_OFF;
    end else begin
      unique case (state_q)
        S_OFF:  state_d = S_WAIT;
        S_WAIT: if (fall) state_d = nold_q ? S_DATA : S_LLOW;
        S_LLOW: if (rise) state_d = llo_ok ? S_LHIGH : S_WAIT;
        S_LHIGH: begin
          if (fall) begin
            if (lhi_ok) begin
              ev_ldr  = 1'b1;
              state_d = S_DATA;
            end else begin
              state_d = S_LLOW;
            end
          end else if (run > lhi_max_q) begin
            state_d = S_WAIT;
          end
        end
        S_DATA: begin
          if (fall) begin
            ev_bit = 1'b1;
          end else if (cyc >= maxc_q) begin
            ev_end     = 1'b1;
            end_is_max = 1'b1;
            state_d    = S_WAIT;
          end else if (!lvl && run > lowl_q) begin
            ev_end  = 1'b1;
            state_d = S_WAIT;
          end
        end
        default: state_d = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_OFF;
    else         state_q <= state_d;
  end

  // bit storage
  logic [BUF_W-1:0] sh_data;
  logic [CW-1:0]    sh_cnt;

  irr_shreg #(.BUF_W(BUF_W)) u_shreg (
    .clk_i, .rst_ni, .clr_i(state_q != S_DATA),
    .shift_i(ev_bit), .bit_i(bit_val), .data_o(sh_data), .cnt_o(sh_cnt)
  );

  // results, flags, interrupts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_o      <= '0;
      rx_bits_o     <= '0;
      end_max_o     <= 1'b0;
      end_low_o     <= 1'b0;
      flag_leader_o <= 1'b0;
      flag_edge_o   <= 1'b0;
      flag_done_o   <= 1'b0;
      irq_leader_o  <= 1'b0;
      irq_edge_o    <= 1'b0;
      irq_done_o    <= 1'b0;
    end else begin
      if (ev_end) begin
        rx_buf_o  <= sh_data;
        rx_bits_o <= sh_cnt;
        end_max_o <= end_is_max;
        end_low_o <= ~end_is_max;
      end
      flag_leader_o <= (flag_leader_o & ~w1c[0]) | ev_ldr;
      flag_edge_o   <= (flag_edge_o & ~w1c[1]) | (ev_bit & eien_q);
      flag_done_o   <= (flag_done_o & ~w1c[2]) | ev_end;
      irq_leader_o  <= ev_ldr & lien_q;
      irq_edge_o    <= ev_bit & eien_q;
      irq_done_o    <= ev_end;
    end
  end
endmodule

// File: rtl/irr_checker.sv
module irr_checker #(
  parameter int BUF_W = 72,
  localparam int CW   = $clog2(BUF_W + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [CW-1:0] rx_bits_o,
  input logic          end_max_o,
  input logic          end_low_o,
  input logic          flag_leader_o,
  input logic          flag_edge_o,
  input logic          flag_done_o,
  input logic          irq_leader_o,
  input logic          irq_edge_o,
  input logic          irq_done_o
);
  assert_quiet_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !(irq_leader_o || irq_edge_o || irq_done_o));

  assert_leader_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_leader_o |-> flag_leader_o);

  assert_edge_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_edge_o |-> flag_edge_o);

  assert_one_reason_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({end_max_o, end_low_o}));

  assert_reason_on_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |-> ($countones({end_max_o, end_low_o}) == 1));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |=> !irq_done_o);

  assert_done_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |-> flag_done_o);

  assert_bits_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_bits_o <= CW'(BUF_W));
endmodule

bind irr_top irr_checker #(.BUF_W(BUF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .rx_bits_o(rx_bits_o),
  .end_max_o(end_max_o), .end_low_o(end_low_o),
  .flag_leader_o(flag_leader_o), .flag_edge_o(flag_edge_o), .flag_done_o(flag_done_o),
  .irq_leader_o(irq_leader_o), .irq_edge_o(irq_edge_o), .irq_done_o(irq_done_o)
);

// File: tb/sim_irr_top.sv
`timescale 1ns/1ps
module sim_irr_top;
  localparam int BW = 72;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        ir = 1'b1;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [BW-1:0] rx_buf;
  logic [6:0]  rx_bits;
  logic        e_max, e_low, f_ldr, f_edge, f_done, i_ldr, i_edge, i_done;

  irr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ir_i(ir),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .rx_buf_o(rx_buf), .rx_bits_o(rx_bits), .end_max_o(e_max), .end_low_o(e_low),
    .flag_leader_o(f_ldr), .flag_edge_o(f_edge), .flag_done_o(f_done),
    .irq_leader_o(i_ldr), .irq_edge_o(i_edge), .irq_done_o(i_done)
  );

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int cnt_ldr = 0, cnt_edge = 0, cnt_done = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [BW-1:0] b;
    int            n;
    bit            mx;
    string         tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input string r, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // monitor: compare each completed frame with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (i_ldr)  cnt_ldr++;
      if (i_edge) cnt_edge++;
      if (i_done) begin
        cnt_done++;
        if (q.size() == 0) begin
          chk("R1 unexpected completion", 72'd1, 72'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " buffer"}, rx_buf, e.b);
          chk({e.tag, " count"}, BW'(rx_bits), BW'(e.n));
          chk({e.tag, " reason"}, BW'({e_max, e_low}), BW'({e.mx, !e.mx}));
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic hold(input logic v, input int c);
    ir = v;
    repeat (c) @(negedge clk);
  endtask

  // ctrl: bit16 leader ien, bit17 edge ien, bit18 leaderless; low limit 60
  task automatic set_ctrl(input bit lien, input bit eien, input bit nold);
    wr(3'd3, {13'd0, nold, eien, lien, 16'd60});
  endtask

  // bits sent in index order 0..n-1; periods 20 (zero) / 40 (one)
  task automatic send(input bit ldr, input int lo, input logic [79:0] bits,
                      input int n, input bit end_low);
    hold(1'b1, 20);
    if (ldr) begin
      hold(1'b0, lo);
      hold(1'b1, 40);
    end
    for (int i = 0; i < n; i++) begin
      hold(1'b0, 8);
      hold(1'b1, bits[i] ? 32 : 12);
    end
    if (end_low) begin
      hold(1'b0, 100);
      hold(1'b1, 20);
    end else begin
      hold(1'b0, 8);
      hold(1'b1, 150);
    end
  endtask

  task automatic expect_frame(input logic [79:0] bits, input int n, input bit mx,
                              input string tag);
    exp_t e;
    e.b = '0;
    for (int i = 0; i < n; i++) e.b = {e.b[BW-2:0], bits[i]};
    e.n   = (n > BW) ? BW : n;
    e.mx  = mx;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int e0, l0, d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset done flag", BW'(f_done), '0);
    chk("R9 reset count", BW'(rx_bits), '0);
    chk("R4 reset buffer", rx_buf, '0);

    wr(3'd0, {16'd90, 16'd70});
    wr(3'd1, {16'd45, 16'd35});
    wr(3'd2, {16'd100, 16'd30});
    set_ctrl(1'b1, 1'b1, 1'b0);
    en = 1'b1;

    // R4 R6: 8 bits, ends on max cycle
    expect_frame(80'hB2, 8, 1'b1, "R4 R6 frame A");
    send(1'b1, 80, 80'hB2, 8, 1'b0);
    chk("R3 leader flag", BW'(f_ldr), 72'd1);
    chk("R3 leader irq count", BW'(cnt_ldr), 72'd1);
    chk("R5 edge irq count", BW'(cnt_edge), 72'd8);
    chk("R8 done count", BW'(cnt_done), 72'd1);

    // R12: clear only leader flag
    wr(3'd4, 32'h1);
    @(negedge clk);
    chk("R12 leader cleared", BW'(f_ldr), '0);
    chk("R12 others kept", BW'({f_edge, f_done}), 72'd3);
    wr(3'd4, 32'h6);
    @(negedge clk);
    chk("R12 edge done cleared", BW'({f_edge, f_done}), '0);

    // R2: leader low too short -> nothing
    d0 = cnt_done;
    send(1'b1, 50, 80'h5A, 8, 1'b0);
    chk("R2 bad leader flag", BW'(f_ldr), '0);
    chk("R2 bad leader no done", BW'(cnt_done), BW'(d0));

    // R7 R3 R5: low end, leader irq and edge irq disabled
    set_ctrl(1'b0, 1'b0, 1'b0);
    l0 = cnt_ldr; e0 = cnt_edge;
    expect_frame(80'h3C9, 10, 1'b0, "R7 frame B");
    send(1'b1, 80, 80'h3C9, 10, 1'b1);
    chk("R3 flag without irq", BW'(f_ldr), 72'd1);
    chk("R3 no leader irq", BW'(cnt_ldr), BW'(l0));
    chk("R5 no edge irq", BW'(cnt_edge), BW'(e0));
    chk("R5 no edge flag", BW'(f_edge), '0);

    // R11: next frame overwrites without clearing
    chk("R11 done still set", BW'(f_done), 72'd1);
    expect_frame(80'h1F, 5, 1'b1, "R11 frame C");
    send(1'b1, 80, 80'h1F, 5, 1'b0);

    // R9: 75 bits saturate at 72
    expect_frame(80'hA5C3_96F0_1E2D_3C4B_5A69, 75, 1'b1, "R9 frame D");
    send(1'b1, 80, 80'hA5C3_96F0_1E2D_3C4B_5A69, 75, 1'b0);

    // R1: disabled, frame ignored
    wr(3'd4, 32'h7);
    en = 1'b0;
    d0 = cnt_done;
    send(1'b1, 80, 80'h33, 8, 1'b0);
    chk("R1 no done when off", BW'(cnt_done), BW'(d0));
    chk("R1 no flags when off", BW'({f_ldr, f_edge, f_done}), '0);
    chk("R1 result kept", BW'(rx_bits), 72'd72);

    // R10: leaderless
    set_ctrl(1'b1, 1'b1, 1'b1);
    en = 1'b1;
    @(negedge clk);
    expect_frame(80'h16, 6, 1'b0, "R10 frame E");
    send(1'b0, 0, 80'h16, 6, 1'b1);
    chk("R10 no leader flag", BW'(f_ldr), '0);
    chk("R10 completed", BW'(f_done), 72'd1);

    repeat (20) @(negedge clk);
    chk("R8 scoreboard drained", BW'(q.size()), '0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule